// File: doc/BRIEF.md
# Four-phase request/acknowledge channel controller

This block moves words across a single-rail data bus that carries two control wires, a request and an acknowledge. A transmit controller takes words from a local valid/ready source and a receive controller hands them to a local valid/ready sink. Every transfer is a full return-to-zero exchange: one wire rises, the other answers, and both are low again before the next exchange may begin. Nothing but these events paces the channel, so a slow peer simply stretches the exchange.

A parameter picks who starts the exchange. In push mode the transmit side raises request with the word already on the bus and the receive side answers with acknowledge. In pull mode the receive side raises request to ask for a word, and the transmit side answers with acknowledge while driving the word. A protocol monitor watches the channel as the receive side sees it. It raises a one-cycle flag when request rises while acknowledge is still high, and another when the bus changes inside its hold window. Both controllers and the monitor run on one clock. The channel inputs are treated as already synchronous.

The two controllers expose their channel pins separately, so they can be tied to each other or to any other peer.

Top module: `hs_link`

## Requirements
- R1: While reset is held and after it, `tx_ctl_o`, `rx_ctl_o`, `dst_valid_o`, `err_order_o` and `err_hold_o` are 0 and `src_ready_o` is 1. In pull mode the receive side raises its request on the first clock edge after reset.
- R2: Push mode. When `src_valid_i` and `src_ready_o` are both high at an edge, the transmit side raises request (`tx_ctl_o`) after that edge and puts the word on `tx_data_o` in the same cycle. `src_ready_o` stays 0 until the exchange has returned to zero.
- R3: Push mode. When the idle receive side sees request high at an edge, it captures `rx_data_i` on that edge. It raises acknowledge (`rx_ctl_o`) and `dst_valid_o` after the same edge.
- R4: Push mode return to zero. The transmit side drops request on the edge after it sees acknowledge high. The receive side drops acknowledge on the edge after it sees request low with `dst_valid_o` low. `src_ready_o` returns to 1 on the edge after the transmit side sees acknowledge low.
- R5: Pull mode. The idle receive side raises request (`rx_ctl_o`) only while its output buffer is empty and acknowledge is low. A transmit side holding a word raises acknowledge (`tx_ctl_o`) on the edge after it sees request high. The receive side captures `rx_data_i` on the edge where it sees acknowledge high and drops request after that edge.
- R6: Pull mode return to zero. The transmit side drops acknowledge and sets `src_ready_o` on the edge after it sees request low. The receive side goes idle on the edge after it sees acknowledge low, and may raise a new request on the edge after that.
- R7: Backpressure. While `dst_valid_o` is 1 and `dst_ready_i` is 0, `dst_data_o` does not change. In push mode acknowledge stays high, so the sender stays busy. In pull mode no new request is raised, so a loaded sender never raises acknowledge.
- R8: Order flag. `err_order_o` is 1 for exactly the cycle after an edge at which request is high, request was low at the previous edge, and acknowledge is high.
- R9: Hold flag. `err_hold_o` is 1 for exactly the cycle after an edge at which `rx_data_i` differs from its value at the previous edge while that previous edge lay in the hold window. In push mode the window is request high and acknowledge low. In pull mode it is request and acknowledge both high.
- R10: With the controllers tied together and the sink always ready, a stream of words arrives at `dst_data_o` in the order sent, each exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid_i | input | 1 | Local source offers a word |
| src_ready_o | output | 1 | Transmit side can accept a word |
| src_data_i | input | DATA_W | Word from the local source |
| tx_ctl_o | output | 1 | Transmit side control wire: request in push mode, acknowledge in pull mode |
| tx_ctl_i | input | 1 | Control wire seen by the transmit side: acknowledge in push mode, request in pull mode |
| tx_data_o | output | DATA_W | Channel data bus driven by the transmit side |
| rx_ctl_o | output | 1 | Receive side control wire: acknowledge in push mode, request in pull mode |
| rx_ctl_i | input | 1 | Control wire seen by the receive side: request in push mode, acknowledge in pull mode |
| rx_data_i | input | DATA_W | Channel data bus seen by the receive side |
| dst_valid_o | output | 1 | Word available to the local sink |
| dst_ready_i | input | 1 | Local sink takes the word |
| dst_data_o | output | DATA_W | Word for the local sink |
| err_order_o | output | 1 | One-cycle flag: request rose while acknowledge was high |
| err_hold_o | output | 1 | One-cycle flag: data changed inside its hold window |

## Verification
The assertions check the local rules on every cycle. Data stays fixed while the transmit control wire stays high. An acknowledge only rises after a request. A pulled request only rises with acknowledge low. A stalled sink output keeps its word, and a stalled push receiver keeps acknowledge high. The exact cycle of each edge in both modes can only be shown by the bench scenarios, as can word ordering across a stream and the two protocol flags. The flags need a misbehaving peer, which the bench plays by driving the receive-side channel pins itself.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic {
        HS_PUSH = 1'b0,
        HS_PULL = 1'b1
    } hs_mode_e;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_LOADED = 2'd1,
        TX_HOLD   = 2'd2,
        TX_RTZ    = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_ACTIVE = 2'd1,
        RX_RTZ    = 2'd2
    } rx_state_e;

endpackage

// File: rtl/hs_tx.sv
module hs_tx
    import hs_pkg::*;
#(
    parameter hs_mode_e MODE   = HS_PUSH,
    parameter int       DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              ctl_o,
    input  logic              ctl_i,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        tx_state_e         st;
        logic              ctl;
        logic [DATA_W-1:0] word;
    } tx_reg_t;

    tx_reg_t cur_q;
    tx_reg_t nxt_d;

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            TX_IDLE: begin
                if (in_valid_i) begin
                    nxt_d.word = in_data_i;
                    if (MODE == HS_PUSH) begin
                        nxt_d.ctl = 1'b1;
                        nxt_d.st  = TX_HOLD;
                    end else begin
                        nxt_d.st  = TX_LOADED;
                    end
                end
            end
            TX_LOADED: begin
                if (ctl_i) begin
                    nxt_d.ctl = 1'b1;
                    nxt_d.st  = TX_HOLD;
                end
            end
            TX_HOLD: begin
                if (MODE == HS_PUSH) begin
                    if (ctl_i) begin
                        nxt_d.ctl = 1'b0;
                        nxt_d.st  = TX_RTZ;
                    end
                end else begin
                    if (!ctl_i) begin
                        nxt_d.ctl = 1'b0;
                        nxt_d.st  = TX_IDLE;
                    end
                end
            end
            TX_RTZ: begin
                if (!ctl_i) begin
                    nxt_d.st = TX_IDLE;
                end
            end
            default: nxt_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: TX_IDLE, ctl: 1'b0, word: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign in_ready_o = (cur_q.st == TX_IDLE);
    assign ctl_o      = cur_q.ctl;
    assign data_o     = cur_q.word;

    AST_TX_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o && $past(ctl_o) |-> $stable(data_o))
        else $error("transmit data moved while control wire held"); // R6

    AST_TX_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i && in_ready_o |=> !in_ready_o)
        else $error("transmit side took a second word"); // R2

    generate
        if (MODE == HS_PUSH) begin : g_push_chk
            AST_TX_REQ_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ctl_o) |-> !ctl_i)
                else $error("request raised with acknowledge high"); // R4
        end
    endgenerate

endmodule

// File: rtl/hs_rx.sv
module hs_rx
    import hs_pkg::*;
#(
    parameter hs_mode_e MODE   = HS_PUSH,
    parameter int       DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              ctl_o,
    input  logic              ctl_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [DATA_W-1:0] out_data_o
);

    typedef struct packed {
        rx_state_e         st;
        logic              ctl;
        logic              vld;
        logic [DATA_W-1:0] word;
    } rx_reg_t;

    rx_reg_t cur_q;
    rx_reg_t nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.vld && out_ready_i) begin
            nxt_d.vld = 1'b0;
        end
        if (MODE == HS_PUSH) begin
            case (cur_q.st)
                RX_IDLE: begin
                    if (ctl_i) begin
                        nxt_d.word = data_i;
                        nxt_d.vld  = 1'b1;
                        nxt_d.ctl  = 1'b1;
                        nxt_d.st   = RX_ACTIVE;
                    end
                end
                RX_ACTIVE: begin
                    if (!ctl_i && !cur_q.vld) begin
                        nxt_d.ctl = 1'b0;
                        nxt_d.st  = RX_IDLE;
                    end
                end
                default: nxt_d.st = RX_IDLE;
            endcase
        end else begin
            case (cur_q.st)
                RX_IDLE: begin
                    if (!cur_q.vld && !ctl_i) begin
                        nxt_d.ctl = 1'b1;
                        nxt_d.st  = RX_ACTIVE;
                    end
                end
                RX_ACTIVE: begin
                    if (ctl_i) begin
                        nxt_d.word = data_i;
                        nxt_d.vld  = 1'b1;
                        nxt_d.ctl  = 1'b0;
                        nxt_d.st   = RX_RTZ;
                    end
                end
                RX_RTZ: begin
                    if (!ctl_i) begin
                        nxt_d.st = RX_IDLE;
                    end
                end
                default: nxt_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: RX_IDLE, ctl: 1'b0, vld: 1'b0, word: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ctl_o       = cur_q.ctl;
    assign out_valid_o = cur_q.vld;
    assign out_data_o  = cur_q.word;

    AST_RX_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o))
        else $error("stalled output word lost or changed"); // R7

    generate
        if (MODE == HS_PUSH) begin : g_push_chk
            AST_RX_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ctl_o) |-> $past(ctl_i))
                else $error("acknowledge rose without a request"); // R3
            AST_RX_ACK_WAITS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
                ctl_o && out_valid_o && !out_ready_i |=> ctl_o)
                else $error("acknowledge fell with a stalled word"); // R7
        end else begin : g_pull_chk
            AST_RX_REQ_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ctl_o) |-> $past(!ctl_i))
                else $error("request raised with acknowledge high"); // R5
        end
    endgenerate

endmodule

// File: rtl/hs_mon.sv
module hs_mon
    import hs_pkg::*;
#(
    parameter hs_mode_e MODE   = HS_PUSH,
    parameter int       DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              ack_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              err_order_o,
    output logic              err_hold_o
);

    typedef struct packed {
        logic              req_prev;
        logic              win_prev;
        logic [DATA_W-1:0] data_prev;
        logic              e_order;
        logic              e_hold;
    } mon_reg_t;

    mon_reg_t cur_q;
    mon_reg_t nxt_d;
    logic     in_window;

    always_comb begin
        if (MODE == HS_PUSH) begin
            in_window = req_i && !ack_i;
        end else begin
            in_window = req_i && ack_i;
        end
        nxt_d.req_prev  = req_i;
        nxt_d.win_prev  = in_window;
        nxt_d.data_prev = data_i;
        nxt_d.e_order   = req_i && !cur_q.req_prev && ack_i;
        nxt_d.e_hold    = cur_q.win_prev && (data_i != cur_q.data_prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{req_prev: 1'b0, win_prev: 1'b0, data_prev: '0,
                       e_order: 1'b0, e_hold: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign err_order_o = cur_q.e_order;
    assign err_hold_o  = cur_q.e_hold;

    AST_MON_ORDER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_order_o |-> $past(req_i) && $past(ack_i))
        else $error("order flag without a raised request under acknowledge"); // R8

endmodule

// File: rtl/hs_link.sv
module hs_link
    import hs_pkg::*;
#(
    parameter hs_mode_e MODE   = HS_PUSH,
    parameter int       DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid_i,
    output logic              src_ready_o,
    input  logic [DATA_W-1:0] src_data_i,
    output logic              tx_ctl_o,
    input  logic              tx_ctl_i,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              rx_ctl_o,
    input  logic              rx_ctl_i,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic              dst_valid_o,
    input  logic              dst_ready_i,
    output logic [DATA_W-1:0] dst_data_o,
    output logic              err_order_o,
    output logic              err_hold_o
);

    logic mon_req;
    logic mon_ack;

    hs_tx #(.MODE(MODE), .DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (src_valid_i),
        .in_ready_o (src_ready_o),
        .in_data_i  (src_data_i),
        .ctl_o      (tx_ctl_o),
        .ctl_i      (tx_ctl_i),
        .data_o     (tx_data_o)
    );

    hs_rx #(.MODE(MODE), .DATA_W(DATA_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_o       (rx_ctl_o),
        .ctl_i       (rx_ctl_i),
        .data_i      (rx_data_i),
        .out_valid_o (dst_valid_o),
        .out_ready_i (dst_ready_i),
        .out_data_o  (dst_data_o)
    );

    generate
        if (MODE == HS_PUSH) begin : g_push_wires
            assign mon_req = rx_ctl_i;
            assign mon_ack = rx_ctl_o;
        end else begin : g_pull_wires
            assign mon_req = rx_ctl_o;
            assign mon_ack = rx_ctl_i;
        end
    endgenerate

    hs_mon #(.MODE(MODE), .DATA_W(DATA_W)) u_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (mon_req),
        .ack_i       (mon_ack),
        .data_i      (rx_data_i),
        .err_order_o (err_order_o),
        .err_hold_o  (err_hold_o)
    );

endmodule

// File: tb/hs_link_bench.sv
module hs_link_bench;
    import hs_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // push instance
    logic          p_src_valid = 1'b0;
    logic [DW-1:0] p_src_data = '0;
    logic          p_src_ready, p_tx_ctl_o, p_rx_ctl_o, p_rx_ctl_i;
    logic [DW-1:0] p_tx_data_o, p_rx_data_i, p_dst_data;
    logic          p_dst_valid, p_err_ord, p_err_hold;
    logic          p_dst_ready = 1'b1;
    logic          p_force = 1'b0, p_fk_ctl = 1'b0;
    logic [DW-1:0] p_fk_data = '0;

    assign p_rx_ctl_i  = p_force ? p_fk_ctl  : p_tx_ctl_o;
    assign p_rx_data_i = p_force ? p_fk_data : p_tx_data_o;

    hs_link #(.MODE(HS_PUSH), .DATA_W(DW)) u_hs_link (
        .clk(clk), .rst_n(rst_n),
        .src_valid_i(p_src_valid), .src_ready_o(p_src_ready), .src_data_i(p_src_data),
        .tx_ctl_o(p_tx_ctl_o), .tx_ctl_i(p_rx_ctl_o), .tx_data_o(p_tx_data_o),
        .rx_ctl_o(p_rx_ctl_o), .rx_ctl_i(p_rx_ctl_i), .rx_data_i(p_rx_data_i),
        .dst_valid_o(p_dst_valid), .dst_ready_i(p_dst_ready), .dst_data_o(p_dst_data),
        .err_order_o(p_err_ord), .err_hold_o(p_err_hold)
    );

    // pull instance
    logic          q_src_valid = 1'b0;
    logic [DW-1:0] q_src_data = '0;
    logic          q_src_ready, q_tx_ctl_o, q_rx_ctl_o, q_rx_ctl_i;
    logic [DW-1:0] q_tx_data_o, q_rx_data_i, q_dst_data;
    logic          q_dst_valid, q_err_ord, q_err_hold;
    logic          q_dst_ready = 1'b1;
    logic          q_force = 1'b0, q_fk_ctl = 1'b0;
    logic [DW-1:0] q_fk_data = '0;

    assign q_rx_ctl_i  = q_force ? q_fk_ctl  : q_tx_ctl_o;
    assign q_rx_data_i = q_force ? q_fk_data : q_tx_data_o;

    hs_link #(.MODE(HS_PULL), .DATA_W(DW)) u_hs_link_pull (
        .clk(clk), .rst_n(rst_n),
        .src_valid_i(q_src_valid), .src_ready_o(q_src_ready), .src_data_i(q_src_data),
        .tx_ctl_o(q_tx_ctl_o), .tx_ctl_i(q_rx_ctl_o), .tx_data_o(q_tx_data_o),
        .rx_ctl_o(q_rx_ctl_o), .rx_ctl_i(q_rx_ctl_i), .rx_data_i(q_rx_data_i),
        .dst_valid_o(q_dst_valid), .dst_ready_i(q_dst_ready), .dst_data_o(q_dst_data),
        .err_order_o(q_err_ord), .err_hold_o(q_err_hold)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        tick();
        check("R1", "push req in reset", p_tx_ctl_o, 0);
        check("R1", "push ack in reset", p_rx_ctl_o, 0);
        check("R1", "push ready in reset", p_src_ready, 1);
        check("R1", "push dst_valid in reset", p_dst_valid, 0);
        check("R1", "pull ack in reset", q_tx_ctl_o, 0);
        check("R1", "pull req in reset", q_rx_ctl_o, 0);
        check("R1", "pull ready in reset", q_src_ready, 1);
        check("R1", "flags in reset", {p_err_ord, p_err_hold, q_err_ord, q_err_hold}, 0);
        rst_n = 1'b1;
        tick();
        check("R1", "push idle after reset", {p_tx_ctl_o, p_rx_ctl_o, p_dst_valid}, 0);
        check("R1", "pull request raised after reset", q_rx_ctl_o, 1);
        check("R1", "pull ack low after reset", q_tx_ctl_o, 0);
    endtask

    task automatic t_push_single();
        p_dst_ready = 1'b1;
        tick();
        check("R2", "ready before send", p_src_ready, 1);
        p_src_valid = 1'b1; p_src_data = 8'hA5;
        tick();
        p_src_valid = 1'b0;
        check("R2", "request raised", p_tx_ctl_o, 1);
        check("R2", "data with request", p_tx_data_o, 8'hA5);
        check("R2", "ready dropped", p_src_ready, 0);
        check("R3", "ack not yet", p_rx_ctl_o, 0);
        tick();
        check("R3", "ack raised", p_rx_ctl_o, 1);
        check("R3", "dst_valid raised", p_dst_valid, 1);
        check("R3", "captured word", p_dst_data, 8'hA5);
        tick();
        check("R4", "request dropped", p_tx_ctl_o, 0);
        check("R4", "ack still high", p_rx_ctl_o, 1);
        check("R4", "word consumed", p_dst_valid, 0);
        tick();
        check("R4", "ack dropped", p_rx_ctl_o, 0);
        check("R4", "ready still low", p_src_ready, 0);
        tick();
        check("R4", "ready restored", p_src_ready, 1);
    endtask

    task automatic send_push(input logic [DW-1:0] w);
        for (int k = 0; k < 20 && !p_src_ready; k++) tick();
        p_src_valid = 1'b1; p_src_data = w;
        tick();
        p_src_valid = 1'b0;
    endtask

    task automatic get_push(input logic [DW-1:0] exp, input string tag);
        for (int k = 0; k < 20 && !p_dst_valid; k++) tick();
        check(tag, "push word delivered", p_dst_valid, 1);
        check(tag, "push word value", p_dst_data, exp);
        tick();
    endtask

    task automatic t_push_stream();
        p_dst_ready = 1'b1;
        for (int i = 0; i < 6; i++) begin
            send_push(8'h10 + 8'(i * 37));
            get_push(8'h10 + 8'(i * 37), "R10");
        end
    endtask

    task automatic t_push_backpressure();
        p_dst_ready = 1'b0;
        send_push(8'hC1);
        for (int k = 0; k < 20 && !p_dst_valid; k++) tick();
        p_src_valid = 1'b1; p_src_data = 8'hD2;
        for (int k = 0; k < 5; k++) begin
            tick();
            check("R7", "push sender blocked", p_src_ready, 0);
            check("R7", "push ack held", p_rx_ctl_o, 1);
            check("R7", "push word held", p_dst_data, 8'hC1);
        end
        p_dst_ready = 1'b1;
        for (int k = 0; k < 20; k++) begin
            tick();
            if (p_src_ready) begin
                tick();
                break;
            end
        end
        p_src_valid = 1'b0;
        get_push(8'hD2, "R7");
    endtask

    task automatic t_push_order_violation();
        for (int k = 0; k < 10 && !p_src_ready; k++) tick();
        p_dst_ready = 1'b0;
        p_fk_data = 8'h5A; p_fk_ctl = 1'b0; p_force = 1'b1;
        tick();
        p_fk_ctl = 1'b1;
        tick();
        check("R8", "fake peer acknowledged", p_rx_ctl_o, 1);
        p_fk_ctl = 1'b0;
        tick();
        check("R8", "ack held for stalled word", p_rx_ctl_o, 1);
        p_fk_ctl = 1'b1;
        tick();
        check("R8", "order flag raised", p_err_ord, 1);
        check("R9", "no hold flag on order fault", p_err_hold, 0);
        tick();
        check("R8", "order flag one cycle", p_err_ord, 0);
        p_fk_ctl = 1'b0; p_dst_ready = 1'b1;
        repeat (4) tick();
        check("R4", "ack back to zero after cleanup", p_rx_ctl_o, 0);
        p_force = 1'b0;
        tick();
    endtask

    task automatic t_push_hold_violation();
        p_dst_ready = 1'b1;
        p_fk_data = 8'h33; p_fk_ctl = 1'b0; p_force = 1'b1;
        tick();
        p_fk_ctl = 1'b1;
        tick();
        p_fk_data = 8'h44;
        check("R9", "no hold flag yet", p_err_hold, 0);
        tick();
        check("R9", "hold flag raised", p_err_hold, 1);
        check("R8", "no order flag on hold fault", p_err_ord, 0);
        p_fk_ctl = 1'b0;
        tick();
        check("R9", "hold flag one cycle", p_err_hold, 0);
        repeat (3) tick();
        p_force = 1'b0;
        tick();
    endtask

    task automatic t_pull_single();
        q_dst_ready = 1'b1;
        for (int k = 0; k < 10 && !q_rx_ctl_o; k++) tick();
        check("R5", "request waiting", q_rx_ctl_o, 1);
        q_src_valid = 1'b1; q_src_data = 8'h3C;
        tick();
        q_src_valid = 1'b0;
        check("R5", "sender loaded", q_src_ready, 0);
        check("R5", "ack not yet", q_tx_ctl_o, 0);
        tick();
        check("R5", "ack raised", q_tx_ctl_o, 1);
        check("R5", "data with ack", q_tx_data_o, 8'h3C);
        check("R5", "no word yet", q_dst_valid, 0);
        tick();
        check("R5", "request dropped", q_rx_ctl_o, 0);
        check("R5", "word delivered", q_dst_valid, 1);
        check("R5", "word value", q_dst_data, 8'h3C);
        check("R6", "ack still high", q_tx_ctl_o, 1);
        tick();
        check("R6", "ack dropped", q_tx_ctl_o, 0);
        check("R6", "sender ready", q_src_ready, 1);
        tick();
        check("R6", "request still low", q_rx_ctl_o, 0);
        tick();
        check("R6", "new request", q_rx_ctl_o, 1);
    endtask

    task automatic send_pull(input logic [DW-1:0] w);
        for (int k = 0; k < 20 && !q_src_ready; k++) tick();
        q_src_valid = 1'b1; q_src_data = w;
        tick();
        q_src_valid = 1'b0;
    endtask

    task automatic get_pull(input logic [DW-1:0] exp, input string tag);
        for (int k = 0; k < 20 && !q_dst_valid; k++) tick();
        check(tag, "pull word delivered", q_dst_valid, 1);
        check(tag, "pull word value", q_dst_data, exp);
        tick();
    endtask

    task automatic t_pull_stream();
        q_dst_ready = 1'b1;
        for (int i = 0; i < 5; i++) begin
            send_pull(8'hE0 ^ 8'(i * 19));
            get_pull(8'hE0 ^ 8'(i * 19), "R10");
        end
    endtask

    task automatic t_pull_backpressure();
        q_dst_ready = 1'b0;
        send_pull(8'h6B);
        for (int k = 0; k < 20 && !q_dst_valid; k++) tick();
        send_pull(8'h7C);
        for (int k = 0; k < 6; k++) begin
            tick();
            check("R7", "pull no new request", q_rx_ctl_o, 0);
            check("R7", "pull sender waits", q_tx_ctl_o, 0);
            check("R7", "pull word held", q_dst_data, 8'h6B);
        end
        q_dst_ready = 1'b1;
        tick();
        get_pull(8'h7C, "R7");
    endtask

    task automatic t_pull_hold_violation();
        q_dst_ready = 1'b1;
        for (int k = 0; k < 10 && !q_rx_ctl_o; k++) tick();
        q_fk_data = 8'h77; q_fk_ctl = 1'b0; q_force = 1'b1;
        tick();
        q_fk_ctl = 1'b1;
        tick();
        check("R5", "forced word captured", q_dst_data, 8'h77);
        q_fk_data = 8'h78;
        tick();
        check("R9", "pull hold flag raised", q_err_hold, 1);
        check("R8", "pull no order flag", q_err_ord, 0);
        q_fk_ctl = 1'b0;
        tick();
        check("R9", "pull hold flag one cycle", q_err_hold, 0);
        repeat (2) tick();
        q_force = 1'b0;
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_push_single();
        t_push_stream();
        t_push_backpressure();
        t_push_order_violation();
        t_push_hold_violation();
        t_pull_single();
        t_pull_stream();
        t_pull_backpressure();
        t_pull_hold_violation();
        repeat (2) tick();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

endmodule